// File: doc/BRIEF.md
# Physical memory protection checker

This block holds a small bank of protection entries and decides, in one combinational pass, whether a physical access may go ahead. Each entry has an 8-bit settings byte and a 32-bit address register that holds a byte address divided by four. A separate 3-bit security register sets global policy. Software changes the bank through a register-style write port. That port honours per-entry locks and a global lock-bypass bit. A read side returns any settings word, address register or the security register.

A lookup takes a 34-bit physical address, an access kind and a privilege flag (machine or user). Every entry decodes its own region from its mode field. The lowest-numbered entry whose region holds the address decides the result. The block reports allow or deny, whether any entry matched, and the number of the deciding entry. Changes written in a cycle become visible to lookups from the next cycle on.

Top module: `pmp_checker`

## Requirements
- R1: After reset every settings byte, address register and the security register read as zero. A lookup then matches nothing: a machine access is allowed and a user access is denied.
- R2: Settings word k holds the bytes of entries 4k to 4k+3, with entry 4k in bits 7:0. In each byte, bit 0 grants read, bit 1 grants write, bit 2 grants execute, bits 4:3 select the mode and bit 7 is the lock.
- R3: Mode 1 (top-of-range) matches addresses from the previous entry's register times four, inclusive, up to the entry's own register times four, exclusive. For entry 0 the lower bound is zero.
- R4: Mode 2 matches exactly the four bytes that start at the register value times four.
- R5: Mode 3 (power-of-two) takes t as the number of trailing ones in the register. It matches 2^(t+3) bytes starting at (reg AND (reg+1)) times four.
- R6: An entry in mode 0 never matches.
- R7: When several entries match, the lowest-numbered one decides, and chk_idx_o reports its number.
- R8: While the bypass bit (security bit 2) is clear, writes to a locked entry's settings byte or address register are ignored. Other bytes in the same word are still written. With bypass set, the writes take effect.
- R9: While bypass is clear, a write to address register i is also ignored when entry i+1 is locked and in mode 1.
- R10: With no match, a user access is denied. A machine access is allowed unless the allow-list bit (security bit 1) is set.
- R11: For a machine access that matches, the entry's permission bit applies only if the entry is locked or lockdown (security bit 0) is set. Otherwise the access is allowed.
- R12: For a user access that matches, the entry's permission bit applies. When lockdown is set and the matching entry is locked, the access is denied.
- R13: chk_acc_i is coded 0 read, 1 write, 2 execute. Code 3 has no permission bit, so it is denied wherever permissions apply.
- R14: Writes and the lookup act on the state that was present at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write enable for a settings word |
| cfg_widx_i | input | 1 | Index of the settings word to write |
| cfg_wdata_i | input | 32 | Data for the settings word |
| addr_we_i | input | 1 | Write enable for an address register |
| addr_widx_i | input | 3 | Index of the address register to write |
| addr_wdata_i | input | 32 | Data for the address register |
| sec_we_i | input | 1 | Write enable for the security register |
| sec_wdata_i | input | 3 | Security data: bit 0 lockdown, bit 1 allow-list, bit 2 bypass |
| cfg_ridx_i | input | 1 | Settings word to read back |
| cfg_rdata_o | output | 32 | Settings word read data |
| addr_ridx_i | input | 3 | Address register to read back |
| addr_rdata_o | output | 32 | Address register read data |
| sec_rdata_o | output | 3 | Security register |
| chk_addr_i | input | 34 | Physical byte address to check |
| chk_acc_i | input | 2 | Access kind |
| chk_mmode_i | input | 1 | 1 for a machine access, 0 for a user access |
| chk_allow_o | output | 1 | Access allowed |
| chk_match_o | output | 1 | Some entry matched |
| chk_idx_o | output | 3 | Number of the deciding entry |

## Verification
A register write and a lookup can fall in the same cycle. So can a settings write that locks entry i+1 as top-of-range and an address write to entry i. Directed steps place both pairs in one cycle: the address write must still take effect, and the lookup must return the old decision. Random steps then issue settings, address, security writes and lookups together. A bench model decides every write from the pre-cycle state and compares the lookup and the read-back against it.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } pmp_mode_e;

  typedef struct packed {
    logic      lock;
    logic [1:0] rsvd;
    pmp_mode_e mode;
    logic      x;
    logic      w;
    logic      r;
  } pmp_cfg_t;

  typedef struct packed {
    logic bypass;
    logic allow_list;
    logic lockdown;
  } pmp_sec_t;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;
endpackage

// File: rtl/pmp_regs.sv
module pmp_regs
  import pmp_pkg::*;
#(
  parameter int unsigned NW = 2,
  parameter int unsigned NE = NW * 4,
  parameter int unsigned CW = (NW > 1) ? $clog2(NW) : 1,
  parameter int unsigned EW = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CW-1:0]        cfg_widx_i,
  input  logic [31:0]          cfg_wdata_i,
  input  logic                 addr_we_i,
  input  logic [EW-1:0]        addr_widx_i,
  input  logic [31:0]          addr_wdata_i,
  input  logic                 sec_we_i,
  input  logic [2:0]           sec_wdata_i,
  input  logic [CW-1:0]        cfg_ridx_i,
  output logic [31:0]          cfg_rdata_o,
  input  logic [EW-1:0]        addr_ridx_i,
  output logic [31:0]          addr_rdata_o,
  output pmp_cfg_t [NE-1:0]    cfg_o,
  output logic [NE-1:0][31:0]  addr_o,
  output pmp_sec_t             sec_o
);
  pmp_cfg_t [NE-1:0]   cfg_q;
  logic [NE-1:0][31:0] addr_q;
  pmp_sec_t            sec_q;
  logic [NW-1:0][31:0] cfg_words;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sec_q <= '0;
    else if (sec_we_i) sec_q <= pmp_sec_t'(sec_wdata_i);
  end

  for (genvar i = 0; i < NE; i++) begin : g_ent
    logic next_tor_lock;
    logic byte_we, adr_we;

    if (i < NE - 1) begin : g_nxt
      assign next_tor_lock = cfg_q[i+1].lock && (cfg_q[i+1].mode == MODE_TOR);
    end else begin : g_last
      assign next_tor_lock = 1'b0;
    end

    assign byte_we = cfg_we_i && (cfg_widx_i == CW'(i / 4)) &&
                     (!cfg_q[i].lock || sec_q.bypass);
    assign adr_we  = addr_we_i && (addr_widx_i == EW'(i)) &&
                     (sec_q.bypass || !(cfg_q[i].lock || next_tor_lock));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[i]  <= '0;
        addr_q[i] <= '0;
      end else begin
        if (byte_we) cfg_q[i] <= pmp_cfg_t'(cfg_wdata_i[8*(i%4) +: 8]);
        if (adr_we)  addr_q[i] <= addr_wdata_i;
      end
    end

    assign cfg_words[i/4][8*(i%4) +: 8] = cfg_q[i];

    assert_lock_cfg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[i].lock && !sec_q.bypass) |=> $stable(cfg_q[i]));
    assert_lock_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[i].lock && !sec_q.bypass) |=> $stable(addr_q[i]));
    if (i < NE - 1) begin : g_tor_chk
      assert_tor_prev_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_q[i+1].lock && cfg_q[i+1].mode == MODE_TOR && !sec_q.bypass)
        |=> $stable(addr_q[i]));
    end
  end

  assign cfg_o        = cfg_q;
  assign addr_o       = addr_q;
  assign sec_o        = sec_q;
  assign cfg_rdata_o  = cfg_words[cfg_ridx_i];
  assign addr_rdata_o = addr_q[addr_ridx_i];
endmodule

// File: rtl/pmp_region_match.sv
module pmp_region_match
  import pmp_pkg::*;
(
  input  pmp_mode_e   mode_i,
  input  logic [31:0] addr_cur_i,
  input  logic [31:0] addr_prev_i,
  input  logic [33:0] chk_addr_i,
  output logic        hit_o
);
  logic [33:0] lo_b, hi_b;
  logic [31:0] pot_mask;

  assign lo_b     = {addr_prev_i, 2'b00};
  assign hi_b     = {addr_cur_i, 2'b00};
  // word-granular mask covering trailing ones plus the first zero
  assign pot_mask = addr_cur_i ^ (addr_cur_i + 32'd1);

  always_comb begin
    unique case (mode_i)
      MODE_TOR:   hit_o = (chk_addr_i >= lo_b) && (chk_addr_i < hi_b);
      MODE_NA4:   hit_o = (chk_addr_i[33:2] == addr_cur_i);
      MODE_NAPOT: hit_o = ((chk_addr_i[33:2] ^ addr_cur_i) & ~pot_mask) == '0;
      default:    hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmp_decide.sv
module pmp_decide
  import pmp_pkg::*;
#(
  parameter int unsigned NE = 8,
  parameter int unsigned EW = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NE-1:0]     hit_i,
  input  pmp_cfg_t [NE-1:0] cfg_i,
  input  pmp_sec_t          sec_i,
  input  logic [1:0]        acc_i,
  input  logic              mmode_i,
  output logic              allow_o,
  output logic              match_o,
  output logic [EW-1:0]     idx_o
);
  pmp_cfg_t sel;
  logic     perm;

  always_comb begin
    match_o = 1'b0;
    idx_o   = '0;
    for (int i = NE - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        match_o = 1'b1;
        idx_o   = EW'(i);
      end
    end
  end

  assign sel = cfg_i[idx_o];

  always_comb begin
    unique case (acc_i)
      ACC_READ:  perm = sel.r;
      ACC_WRITE: perm = sel.w;
      ACC_EXEC:  perm = sel.x;
      default:   perm = 1'b0;
    endcase
  end

  always_comb begin
    if (!match_o)     allow_o = mmode_i && !sec_i.allow_list;
    else if (mmode_i) allow_o = (sel.lock || sec_i.lockdown) ? perm : 1'b1;
    else              allow_o = (sec_i.lockdown && sel.lock) ? 1'b0 : perm;
  end

  assert_idx_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> hit_i[idx_o]);
  assert_idx_lowest_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> ((hit_i & ((NE'(1) << idx_o) - NE'(1))) == '0));
  assert_user_nomatch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_o && !mmode_i) |-> !allow_o);
  assert_user_lockdown_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !mmode_i && sec_i.lockdown && cfg_i[idx_o].lock) |-> !allow_o);
  assert_reserved_acc_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && acc_i == 2'd3 && (!mmode_i || cfg_i[idx_o].lock)) |-> !allow_o);
endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_pkg::*;
#(
  parameter int unsigned NW = 2,
  localparam int unsigned NE = NW * 4,
  localparam int unsigned CW = (NW > 1) ? $clog2(NW) : 1,
  localparam int unsigned EW = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [CW-1:0] cfg_widx_i,
  input  logic [31:0]   cfg_wdata_i,
  input  logic          addr_we_i,
  input  logic [EW-1:0] addr_widx_i,
  input  logic [31:0]   addr_wdata_i,
  input  logic          sec_we_i,
  input  logic [2:0]    sec_wdata_i,
  input  logic [CW-1:0] cfg_ridx_i,
  output logic [31:0]   cfg_rdata_o,
  input  logic [EW-1:0] addr_ridx_i,
  output logic [31:0]   addr_rdata_o,
  output logic [2:0]    sec_rdata_o,
  input  logic [33:0]   chk_addr_i,
  input  logic [1:0]    chk_acc_i,
  input  logic          chk_mmode_i,
  output logic          chk_allow_o,
  output logic          chk_match_o,
  output logic [EW-1:0] chk_idx_o
);
  pmp_cfg_t [NE-1:0]   cfg;
  logic [NE-1:0][31:0] addr;
  pmp_sec_t            sec;
  logic [NE-1:0]       hit;

  pmp_regs #(.NW(NW), .NE(NE), .CW(CW), .EW(EW)) u_regs (
    .clk_i, .rst_ni,
    .cfg_we_i, .cfg_widx_i, .cfg_wdata_i,
    .addr_we_i, .addr_widx_i, .addr_wdata_i,
    .sec_we_i, .sec_wdata_i,
    .cfg_ridx_i, .cfg_rdata_o,
    .addr_ridx_i, .addr_rdata_o,
    .cfg_o(cfg), .addr_o(addr), .sec_o(sec)
  );

  for (genvar i = 0; i < NE; i++) begin : g_match
    logic [31:0] prev;
    if (i == 0) begin : g_first
      assign prev = '0;
    end else begin : g_rest
      assign prev = addr[i-1];
    end
    pmp_region_match u_match (
      .mode_i(cfg[i].mode), .addr_cur_i(addr[i]), .addr_prev_i(prev),
      .chk_addr_i, .hit_o(hit[i])
    );
  end

  pmp_decide #(.NE(NE), .EW(EW)) u_decide (
    .clk_i, .rst_ni, .hit_i(hit), .cfg_i(cfg), .sec_i(sec),
    .acc_i(chk_acc_i), .mmode_i(chk_mmode_i),
    .allow_o(chk_allow_o), .match_o(chk_match_o), .idx_o(chk_idx_o)
  );

  assign sec_rdata_o = sec;
endmodule

// File: tb/tb_pmp_checker.sv
`timescale 1ns/1ps
module tb_pmp_checker;
  localparam int NW = 2;
  localparam int NE = NW * 4;

  logic        clk = 0, rst_ni = 0;
  logic        cfg_we = 0, addr_we = 0, sec_we = 0;
  logic [0:0]  cfg_widx = 0, cfg_ridx = 0;
  logic [31:0] cfg_wdata = 0, addr_wdata = 0, cfg_rdata, addr_rdata;
  logic [2:0]  addr_widx = 0, addr_ridx = 0, chk_idx;
  logic [2:0]  sec_wdata = 0, sec_rdata;
  logic [33:0] chk_addr = 0;
  logic [1:0]  chk_acc = 0;
  logic        chk_mm = 0, chk_allow, chk_match;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bit [7:0]  m_cfg[NE];
  bit [31:0] m_addr[NE];
  bit [2:0]  m_sec;

  always #2.5 clk = ~clk;

  pmp_checker #(.NW(NW)) dut (
    .clk_i(clk), .rst_ni,
    .cfg_we_i(cfg_we), .cfg_widx_i(cfg_widx), .cfg_wdata_i(cfg_wdata),
    .addr_we_i(addr_we), .addr_widx_i(addr_widx), .addr_wdata_i(addr_wdata),
    .sec_we_i(sec_we), .sec_wdata_i(sec_wdata),
    .cfg_ridx_i(cfg_ridx), .cfg_rdata_o(cfg_rdata),
    .addr_ridx_i(addr_ridx), .addr_rdata_o(addr_rdata), .sec_rdata_o(sec_rdata),
    .chk_addr_i(chk_addr), .chk_acc_i(chk_acc), .chk_mmode_i(chk_mm),
    .chk_allow_o(chk_allow), .chk_match_o(chk_match), .chk_idx_o(chk_idx)
  );

  function automatic bit m_hit(int i, bit [33:0] a);
    bit [31:0] r = m_addr[i];
    longint unsigned lo, base, size, t;
    case (m_cfg[i][4:3])
      2'd1: begin
        lo = (i == 0) ? 0 : longint'(m_addr[i-1]) * 4;
        return (a >= lo) && (a < longint'(r) * 4);
      end
      2'd2: return (a >= longint'(r) * 4) && (a < longint'(r) * 4 + 4);
      2'd3: begin
        t = 0;
        while (t < 32 && r[t]) t++;
        size = 64'd1 << (t + 3);
        base = longint'(r & (r + 32'd1)) * 4;
        return (a >= base) && (a < base + size);
      end
      default: return 0;
    endcase
  endfunction

  function automatic void m_decide(bit [33:0] a, bit [1:0] acc, bit mm,
                                   output bit allow, output bit match, output int idx);
    bit perm, lk;
    match = 0; idx = 0;
    for (int i = NE - 1; i >= 0; i--) if (m_hit(i, a)) begin match = 1; idx = i; end
    if (!match) begin allow = mm && !m_sec[1]; return; end
    perm = (acc == 2'd3) ? 1'b0 : m_cfg[idx][acc];
    lk   = m_cfg[idx][7];
    if (mm) allow = (lk || m_sec[0]) ? perm : 1'b1;
    else    allow = (m_sec[0] && lk) ? 1'b0 : perm;
  endfunction

  task automatic fail_line(string req, string what, longint act, longint exp);
    n_fail++;
    $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
  endtask

  task automatic check(bit [33:0] a, bit [1:0] acc, bit mm, string req);
    bit ea, em; int ei;
    chk_addr = a; chk_acc = acc; chk_mm = mm;
    #0.5;
    m_decide(a, acc, mm, ea, em, ei);
    n_chk++;
    if (chk_match !== em) fail_line(req, "match", chk_match, em);
    else if (chk_allow !== ea) fail_line(req, "allow", chk_allow, ea);
    else if (em && chk_idx !== 3'(ei)) fail_line(req, "idx", chk_idx, ei);
  endtask

  task automatic check_regs(string req);
    for (int w = 0; w < NW; w++) begin
      cfg_ridx = 1'(w); #0.2;
      n_chk++;
      if (cfg_rdata !== {m_cfg[4*w+3], m_cfg[4*w+2], m_cfg[4*w+1], m_cfg[4*w]})
        fail_line(req, "cfg word", cfg_rdata,
                  {m_cfg[4*w+3], m_cfg[4*w+2], m_cfg[4*w+1], m_cfg[4*w]});
    end
    for (int e = 0; e < NE; e++) begin
      addr_ridx = 3'(e); #0.2;
      n_chk++;
      if (addr_rdata !== m_addr[e]) fail_line(req, "addr reg", addr_rdata, m_addr[e]);
    end
    n_chk++;
    if (sec_rdata !== m_sec) fail_line(req, "sec", sec_rdata, m_sec);
  endtask

  // one write cycle; model decisions use state from before the edge (R14)
  task automatic wr(bit ce, bit [0:0] cw, bit [31:0] cd,
                    bit ae, bit [2:0] aw, bit [31:0] ad,
                    bit se, bit [2:0] sd);
    bit [7:0] nc[NE]; bit [31:0] na[NE]; bit byp;
    @(negedge clk);
    cfg_we = ce; cfg_widx = cw; cfg_wdata = cd;
    addr_we = ae; addr_widx = aw; addr_wdata = ad;
    sec_we = se; sec_wdata = sd;
    byp = m_sec[2];
    nc = m_cfg; na = m_addr;
    for (int e = 0; e < NE; e++) begin
      if (ce && cw == 1'(e / 4) && (!m_cfg[e][7] || byp)) nc[e] = cd[8*(e%4) +: 8];
      if (ae && aw == 3'(e) && (byp || !(m_cfg[e][7] ||
          (e < NE - 1 && m_cfg[e+1][7] && m_cfg[e+1][4:3] == 2'd1))))
        na[e] = ad;
    end
    @(posedge clk);
    #1;
    cfg_we = 0; addr_we = 0; sec_we = 0;
    m_cfg = nc; m_addr = na;
    if (se) m_sec = sd;
  endtask

  task automatic wcfg(int w, bit [31:0] d);  wr(1, 1'(w), d, 0, 0, 0, 0, 0); endtask
  task automatic waddr(int e, bit [31:0] d); wr(0, 0, 0, 1, 3'(e), d, 0, 0); endtask
  task automatic wsec(bit [2:0] d);          wr(0, 0, 0, 0, 0, 0, 1, d); endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0;
    for (int e = 0; e < NE; e++) begin m_cfg[e] = 0; m_addr[e] = 0; end
    m_sec = 0;
    @(negedge clk); @(negedge clk); rst_ni = 1;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    do_reset();
    // R1 reset state
    check_regs("R1");
    check(34'h0_1000, 0, 1, "R1");
    check(34'h0_1000, 0, 0, "R1");

    // R2/R3: entry0 off base, entry1 TOR read-only; entry2 NA4 RW; entry3 NAPOT R
    waddr(0, 32'h400); waddr(1, 32'h800); waddr(2, 32'h1000); waddr(3, 32'h20FF);
    wcfg(0, {8'h19, 8'h13, 8'h09, 8'h00});
    check_regs("R2");
    check(34'h0_0FFC, 0, 0, "R6");
    check(34'h0_1000, 0, 0, "R3");
    check(34'h0_1FFC, 1, 0, "R3");
    check(34'h0_2000, 0, 0, "R3");
    check(34'h0_4000, 1, 0, "R4");
    check(34'h0_4003, 0, 0, "R4");
    check(34'h0_4004, 0, 0, "R4");
    check(34'h0_3FFC, 0, 0, "R4");
    check(34'h0_8000, 0, 0, "R5");
    check(34'h0_87FF, 0, 0, "R5");
    check(34'h0_8800, 0, 0, "R5");
    check(34'h0_7FFC, 0, 0, "R5");
    check(34'h0_8000, 2, 0, "R13");
    check(34'h0_8000, 3, 0, "R13");

    // R7: entry4 wide NAPOT RWX overlaps entry3
    waddr(4, 32'h21FF);
    wcfg(1, {24'h0, 8'h1F});
    check(34'h0_8000, 1, 0, "R7");
    check(34'h0_8900, 1, 0, "R7");

    // R11: unlocked entry3 machine write allowed, then lock it
    check(34'h0_8000, 1, 1, "R11");
    wcfg(0, {8'h99, 8'h13, 8'h09, 8'h00});
    check(34'h0_8000, 1, 1, "R11");
    // R8: locked writes ignored; neighbour byte in same word still written
    waddr(3, 32'h0);
    wcfg(0, {8'h1F, 8'h17, 8'h09, 8'h00});
    check_regs("R8");
    wsec(3'b100);
    waddr(3, 32'h20FF);
    wcfg(0, {8'h19, 8'h13, 8'h09, 8'h00});
    check_regs("R8");
    wsec(3'b000);

    // R14 + R9: lock entry1 TOR while writing addr0 in the same cycle; addr write lands
    wr(1, 0, {8'h19, 8'h13, 8'h89, 8'h00}, 1, 0, 32'h480, 0, 0);
    check_regs("R14");
    waddr(0, 32'h100);
    check_regs("R9");
    check(34'h0_1200, 1, 1, "R11");

    // R10 allow-list and R11/R12 lockdown
    check(34'h1_0000, 0, 1, "R10");
    wsec(3'b010);
    check(34'h1_0000, 0, 1, "R10");
    check(34'h1_0000, 0, 0, "R10");
    check(34'h0_4000, 2, 1, "R11");
    wsec(3'b001);
    check(34'h0_4000, 2, 1, "R11");
    check(34'h0_1200, 0, 0, "R12");
    check(34'h0_4000, 0, 0, "R12");

    // R14: lookup in a write cycle sees old state
    @(negedge clk);
    sec_we = 1; sec_wdata = 3'b000;
    check(34'h0_4000, 2, 1, "R14");
    @(posedge clk); #1; sec_we = 0; m_sec = 0;
    check(34'h0_4000, 2, 1, "R14");

    // random phase
    do_reset();
    for (int it = 0; it < 3000; it++) begin
      int k = $urandom_range(0, 9);
      bit [33:0] a;
      if (k < 4) begin
        bit [31:0] cd = $urandom;
        for (int b = 0; b < 4; b++) if ($urandom_range(0, 3) != 0) cd[8*b+7] = 0;
        wr($urandom_range(0, 1), 1'($urandom_range(0, NW - 1)), cd,
           $urandom_range(0, 1), 3'($urandom_range(0, NE - 1)),
           ($urandom_range(0, 1) ? $urandom : ($urandom & 32'h3FFF)),
           ($urandom_range(0, 3) == 0), 3'($urandom));
        check_regs("R8");
      end
      begin
        int e = $urandom_range(0, NE - 1);
        case ($urandom_range(0, 2))
          0: a = 34'($urandom);
          1: a = {m_addr[e], 2'b00} + 34'($urandom_range(0, 8)) - 34'd4;
          default: a = {m_addr[e] & (m_addr[e] + 32'd1), 2'b00} - 34'($urandom_range(0, 1));
        endcase
      end
      check(a, 2'($urandom), $urandom_range(0, 1), "R7");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule